// File: doc/BRIEF.md
# Dual-Direction Host Mailbox Bridge

This block passes 32-bit messages in both directions between an external host and an internal processor. The host has a 16-bit parallel bus with a bank select and a two-bit address. The processor has a 32-bit register port. The host builds the inbound message from two 16-bit halves. Storing the upper half marks the message as ready for the processor. The processor takes the message by pulsing a read strobe, which clears that ready mark.

In the other direction, the processor writes a whole 32-bit outbound word, and this raises a ready mark that the host can see. The host fetches the word as two halves. Fetching the upper half withdraws the ready mark. A host status word shows both marks.

All host strobes are treated as single-cycle enables in the core clock domain. Host read data is registered and appears one cycle after the read strobe.

Top module: `host_mailbox_bridge`

## Requirements
- R1: After reset, all four mailbox halves are 0x0000, both ready flags are 0 and `host_rdata` is 0x0000.
- R2: A host write with bank 4'b0010 and address 2'b00 stores the lower 16 bits of the inbound word. It leaves the inbound flag unchanged. The host can read the value back at the same location.
- R3: A host write with bank 4'b0010 and address 2'b01 stores the upper 16 bits of the inbound word. It sets `core_in_flag` at the same clock edge. The host can read the value back.
- R4: A `core_in_rd` pulse clears `core_in_flag` at that edge. If a host upper-half inbound write falls in the same cycle, the flag stays 1.
- R5: A `core_out_wr` pulse stores `core_out_wdata` and sets `core_out_flag`. The host reads the outbound word at bank 4'b0011: address 2'b00 gives bits 15:0 and address 2'b01 gives bits 31:16.
- R6: A host read of bank 4'b0011, address 2'b01 clears the outbound flag at that edge. If `core_out_wr` falls in the same cycle, the flag stays set, and the read returns the upper half as it was before the write.
- R7: A host read of bank 4'b0011, address 2'b10 returns a status word. Bit 0 is the outbound flag, bit 1 is the inbound flag, and all other bits are 0.
- R8: Host writes to bank 4'b0011 change neither the outbound word nor any flag.
- R9: Host reads of any bank and address not listed in R2, R3, R5 and R7 return 0x0000. Host writes there change nothing.
- R10: `host_rdata` is loaded on the clock edge that samples `host_rd`. It holds its value while `host_rd` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Synchronous active-low reset |
| host_bank | input | 4 | Host bank select |
| host_addr | input | 2 | Host register address within the bank |
| host_wr | input | 1 | Host write enable, one cycle |
| host_rd | input | 1 | Host read enable, one cycle |
| host_wdata | input | HALF_W | Host write data |
| host_rdata | output | HALF_W | Registered host read data |
| core_in_rd | input | 1 | Processor read of the inbound word, one cycle |
| core_in_data | output | 2*HALF_W | Inbound word |
| core_in_flag | output | 1 | Inbound word ready |
| core_out_wr | input | 1 | Processor write of the outbound word, one cycle |
| core_out_wdata | input | 2*HALF_W | Outbound word to store |
| core_out_flag | output | 1 | Outbound word not yet fetched by the host |

## Verification
Two pairs of events can collide in one cycle. The first pair is a host upper-half inbound write and a processor read. The second pair is a processor outbound write and a host upper-half outbound read. The bench drives each pair on the same clock edge. It then judges the flag, which must stay set in both cases. For the outbound pair it also checks that the host read returned the pre-write upper half, and that a later read returns the new word. A full sweep over every bank and address, with writes and reads, compares each result against a model kept in the bench.

// File: rtl/mbx_pkg.sv
// Shared constants and types for the host mailbox bridge.
// Assumes the host address map is fixed: inbound bank, outbound bank, status slot.
package mbx_pkg;
    localparam int BANK_W = 4;
    localparam int ADDR_W = 2;

    localparam logic [BANK_W-1:0] BANK_INBOX  = 4'b0010;
    localparam logic [BANK_W-1:0] BANK_OUTBOX = 4'b0011;
    localparam logic [ADDR_W-1:0] ADR_LO      = 2'b00;
    localparam logic [ADDR_W-1:0] ADR_HI      = 2'b01;
    localparam logic [ADDR_W-1:0] ADR_STAT    = 2'b10;

    typedef enum logic [2:0] {
        SEL_NONE,
        SEL_IN_LO,
        SEL_IN_HI,
        SEL_OUT_LO,
        SEL_OUT_HI,
        SEL_STAT
    } mbx_sel_e;
endpackage

// File: rtl/mbx_decode.sv
// Host address decoder: maps bank select and address onto one mailbox slot.
// Assumes a purely combinational decode; an unmapped pair yields SEL_NONE.
module mbx_decode
    import mbx_pkg::*;
(
    input  logic [BANK_W-1:0] bank,
    input  logic [ADDR_W-1:0] addr,
    output mbx_sel_e          sel
);
    // Slot selection from bank and address.
    always_comb begin
        sel = SEL_NONE;
        if (bank == BANK_INBOX) begin
            if (addr == ADR_LO)      sel = SEL_IN_LO;
            else if (addr == ADR_HI) sel = SEL_IN_HI;
        end else if (bank == BANK_OUTBOX) begin
            if (addr == ADR_LO)        sel = SEL_OUT_LO;
            else if (addr == ADR_HI)   sel = SEL_OUT_HI;
            else if (addr == ADR_STAT) sel = SEL_STAT;
        end
    end
endmodule

// File: rtl/mbx_in_box.sv
// Inbound mailbox: host writes two halves; the upper-half write raises the ready flag.
// Assumes single-cycle write and read strobes. A set beats a simultaneous processor read.
module mbx_in_box #(
    parameter int HALF_W = 16,
    localparam int WORD_W = 2 * HALF_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_lo,
    input  logic              wr_hi,
    input  logic [HALF_W-1:0] wdata,
    input  logic              core_rd,
    output logic [WORD_W-1:0] word,
    output logic              flag
);
    logic [HALF_W-1:0] half_q [2];

    // Half-word storage; index 0 is the lower half.
    for (genvar g = 0; g < 2; g++) begin : g_half
        logic wen;
        assign wen = (g == 0) ? wr_lo : wr_hi;
        always_ff @(posedge clk) begin
            if (!rst_n)   half_q[g] <= '0;
            else if (wen) half_q[g] <= wdata;
        end
    end

    // Ready flag: set by the upper-half write, cleared by the processor read.
    always_ff @(posedge clk) begin
        if (!rst_n)       flag <= 1'b0;
        else if (wr_hi)   flag <= 1'b1;
        else if (core_rd) flag <= 1'b0;
    end

    assign word = {half_q[1], half_q[0]};

    a_r3_hi_write_sets: assert property (@(posedge clk) disable iff (!rst_n)
        wr_hi |=> flag && word[WORD_W-1:HALF_W] == $past(wdata));
    a_r4_read_clears: assert property (@(posedge clk) disable iff (!rst_n)
        core_rd && !wr_hi |=> !flag);
    a_r2_lo_write_keeps_flag: assert property (@(posedge clk) disable iff (!rst_n)
        wr_lo && !wr_hi && !core_rd |=> $stable(flag) && word[HALF_W-1:0] == $past(wdata));
endmodule

// File: rtl/mbx_out_box.sv
// Outbound mailbox: the processor writes a full word and raises the flag.
// The host upper-half read clears the flag. Assumes single-cycle strobes; a set beats a clear.
module mbx_out_box #(
    parameter int WORD_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              core_wr,
    input  logic [WORD_W-1:0] core_wdata,
    input  logic              host_rd_hi,
    output logic [WORD_W-1:0] word,
    output logic              flag
);
    // Outbound word storage.
    always_ff @(posedge clk) begin
        if (!rst_n)       word <= '0;
        else if (core_wr) word <= core_wdata;
    end

    // Ready flag: set by the processor write, cleared by the host upper-half read.
    always_ff @(posedge clk) begin
        if (!rst_n)          flag <= 1'b0;
        else if (core_wr)    flag <= 1'b1;
        else if (host_rd_hi) flag <= 1'b0;
    end

    a_r5_write_sets: assert property (@(posedge clk) disable iff (!rst_n)
        core_wr |=> flag && word == $past(core_wdata));
    a_r6_hi_read_clears: assert property (@(posedge clk) disable iff (!rst_n)
        host_rd_hi && !core_wr |=> !flag);
endmodule

// File: rtl/host_mailbox_bridge.sv
// Top of the host mailbox bridge. It decodes host accesses, routes them into the two
// mailboxes and registers host read data with one cycle of latency.
// Assumes the host strobes are already synchronous to clk and last one cycle.
module host_mailbox_bridge
    import mbx_pkg::*;
#(
    parameter int HALF_W = 16
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [3:0]          host_bank,
    input  logic [1:0]          host_addr,
    input  logic                host_wr,
    input  logic                host_rd,
    input  logic [HALF_W-1:0]   host_wdata,
    output logic [HALF_W-1:0]   host_rdata,
    input  logic                core_in_rd,
    output logic [2*HALF_W-1:0] core_in_data,
    output logic                core_in_flag,
    input  logic                core_out_wr,
    input  logic [2*HALF_W-1:0] core_out_wdata,
    output logic                core_out_flag
);
    localparam int WORD_W = 2 * HALF_W;

    mbx_sel_e          sel;
    logic [WORD_W-1:0] out_word;
    logic [HALF_W-1:0] rd_mux;

    mbx_decode u_decode (
        .bank (host_bank),
        .addr (host_addr),
        .sel  (sel)
    );

    mbx_in_box #(.HALF_W(HALF_W)) u_in_box (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_lo   (host_wr && sel == SEL_IN_LO),
        .wr_hi   (host_wr && sel == SEL_IN_HI),
        .wdata   (host_wdata),
        .core_rd (core_in_rd),
        .word    (core_in_data),
        .flag    (core_in_flag)
    );

    mbx_out_box #(.WORD_W(WORD_W)) u_out_box (
        .clk        (clk),
        .rst_n      (rst_n),
        .core_wr    (core_out_wr),
        .core_wdata (core_out_wdata),
        .host_rd_hi (host_rd && sel == SEL_OUT_HI),
        .word       (out_word),
        .flag       (core_out_flag)
    );

    // Host read data selection from the decoded slot.
    always_comb begin
        unique case (sel)
            SEL_IN_LO:  rd_mux = core_in_data[HALF_W-1:0];
            SEL_IN_HI:  rd_mux = core_in_data[WORD_W-1:HALF_W];
            SEL_OUT_LO: rd_mux = out_word[HALF_W-1:0];
            SEL_OUT_HI: rd_mux = out_word[WORD_W-1:HALF_W];
            SEL_STAT:   rd_mux = {{(HALF_W-2){1'b0}}, core_in_flag, core_out_flag};
            default:    rd_mux = '0;
        endcase
    end

    // Registered host read data, held between reads.
    always_ff @(posedge clk) begin
        if (!rst_n)       host_rdata <= '0;
        else if (host_rd) host_rdata <= rd_mux;
    end

    a_r10_hold_idle: assert property (@(posedge clk) disable iff (!rst_n)
        !host_rd |=> $stable(host_rdata));
    a_r9_unmapped_zero: assert property (@(posedge clk) disable iff (!rst_n)
        host_rd && sel == SEL_NONE |=> host_rdata == '0);
    a_r8_host_write_outbox_ignored: assert property (@(posedge clk) disable iff (!rst_n)
        host_wr && host_bank == BANK_OUTBOX && !core_out_wr && !host_rd
        |=> $stable(out_word) && $stable(core_out_flag));
    a_r7_status_bits: assert property (@(posedge clk) disable iff (!rst_n)
        host_rd && sel == SEL_STAT
        |=> host_rdata == {{(HALF_W-2){1'b0}}, $past(core_in_flag), $past(core_out_flag)});
endmodule

// File: tb/host_mailbox_bridge_bench.sv
module host_mailbox_bridge_bench;
    localparam int HW = 16;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [3:0]    host_bank = '0;
    logic [1:0]    host_addr = '0;
    logic          host_wr = 1'b0;
    logic          host_rd = 1'b0;
    logic [HW-1:0] host_wdata = '0;
    logic [HW-1:0] host_rdata;
    logic          core_in_rd = 1'b0;
    logic [2*HW-1:0] core_in_data;
    logic          core_in_flag;
    logic          core_out_wr = 1'b0;
    logic [2*HW-1:0] core_out_wdata = '0;
    logic          core_out_flag;

    int checks = 0;
    int fails = 0;

    // Bench model of the mailbox state.
    logic [HW-1:0] m_inlo = '0, m_inhi = '0;
    logic [2*HW-1:0] m_out = '0;
    logic m_inflag = 1'b0, m_outflag = 1'b0;

    host_mailbox_bridge #(.HALF_W(HW)) u_host_mailbox_bridge (
        .clk(clk), .rst_n(rst_n),
        .host_bank(host_bank), .host_addr(host_addr),
        .host_wr(host_wr), .host_rd(host_rd),
        .host_wdata(host_wdata), .host_rdata(host_rdata),
        .core_in_rd(core_in_rd), .core_in_data(core_in_data), .core_in_flag(core_in_flag),
        .core_out_wr(core_out_wr), .core_out_wdata(core_out_wdata),
        .core_out_flag(core_out_flag)
    );

    always #4 clk = ~clk;

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    function automatic logic [HW-1:0] model_rd(input logic [3:0] b, input logic [1:0] a);
        if (b == 4'b0010 && a == 2'b00) return m_inlo;
        if (b == 4'b0010 && a == 2'b01) return m_inhi;
        if (b == 4'b0011 && a == 2'b00) return m_out[15:0];
        if (b == 4'b0011 && a == 2'b01) return m_out[31:16];
        if (b == 4'b0011 && a == 2'b10) return {14'b0, m_inflag, m_outflag};
        return '0;
    endfunction

    task automatic host_write(input logic [3:0] b, input logic [1:0] a, input logic [HW-1:0] d);
        @(negedge clk);
        host_bank = b; host_addr = a; host_wdata = d; host_wr = 1'b1;
        @(negedge clk);
        host_wr = 1'b0;
        if (b == 4'b0010 && a == 2'b00) m_inlo = d;
        if (b == 4'b0010 && a == 2'b01) begin m_inhi = d; m_inflag = 1'b1; end
    endtask

    task automatic host_read(input logic [3:0] b, input logic [1:0] a, output logic [HW-1:0] d);
        @(negedge clk);
        host_bank = b; host_addr = a; host_rd = 1'b1;
        @(negedge clk);
        host_rd = 1'b0;
        d = host_rdata;
        if (b == 4'b0011 && a == 2'b01) m_outflag = 1'b0;
    endtask

    task automatic core_write(input logic [31:0] d);
        @(negedge clk);
        core_out_wr = 1'b1; core_out_wdata = d;
        @(negedge clk);
        core_out_wr = 1'b0;
        m_out = d; m_outflag = 1'b1;
    endtask

    // Watchdog: a hung run counts as a failure and still prints the summary.
    initial begin
        repeat (200000) @(posedge clk);
        fails++;
        $display("FAIL watchdog actual=timeout expected=completion");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        logic [HW-1:0] rd;
        logic [HW-1:0] exp;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1: reset state
        chk("R1 rdata", 32'(host_rdata), 32'h0);
        chk("R1 in_data", core_in_data, 32'h0);
        chk("R1 in_flag", 32'(core_in_flag), 32'h0);
        chk("R1 out_flag", 32'(core_out_flag), 32'h0);
        host_read(4'b0011, 2'b00, rd); chk("R1 out lo", 32'(rd), 32'h0);
        host_read(4'b0011, 2'b01, rd); chk("R1 out hi", 32'(rd), 32'h0);

        // R2: lower write keeps flag low
        host_write(4'b0010, 2'b00, 16'hA55A);
        chk("R2 flag unchanged", 32'(core_in_flag), 32'h0);
        chk("R2 in_data", core_in_data, 32'h0000_A55A);
        host_read(4'b0010, 2'b00, rd); chk("R2 readback", 32'(rd), 32'hA55A);

        // R3: upper write sets the flag
        host_write(4'b0010, 2'b01, 16'h1234);
        chk("R3 flag set", 32'(core_in_flag), 32'h1);
        chk("R3 in_data", core_in_data, 32'h1234_A55A);
        host_read(4'b0010, 2'b01, rd); chk("R3 readback", 32'(rd), 32'h1234);

        // R7: status shows the inbound flag on bit 1
        host_read(4'b0011, 2'b10, rd); chk("R7 status in", 32'(rd), 32'h2);

        // R4: processor read clears the flag
        @(negedge clk); core_in_rd = 1'b1;
        @(negedge clk); core_in_rd = 1'b0; m_inflag = 1'b0;
        chk("R4 clear", 32'(core_in_flag), 32'h0);
        // R4: collision of upper write and processor read keeps the flag
        @(negedge clk);
        core_in_rd = 1'b1; host_bank = 4'b0010; host_addr = 2'b01;
        host_wdata = 16'hBEEF; host_wr = 1'b1;
        @(negedge clk);
        core_in_rd = 1'b0; host_wr = 1'b0; m_inhi = 16'hBEEF; m_inflag = 1'b1;
        chk("R4 collision keeps flag", 32'(core_in_flag), 32'h1);
        chk("R4 collision data", core_in_data, 32'hBEEF_A55A);

        // R5: processor write sets the outbound flag; host reads both halves
        core_write(32'hCAFE_0F0F);
        chk("R5 flag set", 32'(core_out_flag), 32'h1);
        host_read(4'b0011, 2'b10, rd); chk("R7 status both", 32'(rd), 32'h3);
        host_read(4'b0011, 2'b00, rd); chk("R5 out lo", 32'(rd), 32'h0F0F);
        chk("R6 lo read keeps flag", 32'(core_out_flag), 32'h1);
        host_read(4'b0011, 2'b01, rd); chk("R5 out hi", 32'(rd), 32'hCAFE);
        chk("R6 hi read clears", 32'(core_out_flag), 32'h0);

        // R6: collision of processor write and host upper read
        @(negedge clk);
        core_out_wr = 1'b1; core_out_wdata = 32'h7777_8888;
        host_bank = 4'b0011; host_addr = 2'b01; host_rd = 1'b1;
        @(negedge clk);
        core_out_wr = 1'b0; host_rd = 1'b0;
        m_out = 32'h7777_8888; m_outflag = 1'b1;
        chk("R6 collision set wins", 32'(core_out_flag), 32'h1);
        chk("R6 collision old data", 32'(host_rdata), 32'hCAFE);
        host_read(4'b0011, 2'b01, rd); chk("R6 new hi", 32'(rd), 32'h7777);

        // R8: host writes to the outbound bank are ignored
        core_write(32'h0102_0304);
        for (int a = 0; a < 4; a++) host_write(4'b0011, 2'(a), 16'hFFFF);
        chk("R8 flag kept", 32'(core_out_flag), 32'h1);
        host_read(4'b0011, 2'b00, rd); chk("R8 lo kept", 32'(rd), 32'h0304);

        // R10: data holds while idle
        repeat (3) @(negedge clk);
        chk("R10 hold", 32'(host_rdata), 32'h0304);

        // R9/R2/R3/R7: sweep writes then reads over every bank and address
        for (int b = 0; b < 16; b++)
            for (int a = 0; a < 4; a++)
                host_write(4'(b), 2'(a), 16'(b * 4 + a + 16'h5100));
        chk("R9 in_data after sweep", core_in_data, {m_inhi, m_inlo});
        for (int b = 0; b < 16; b++)
            for (int a = 0; a < 4; a++) begin
                exp = model_rd(4'(b), 2'(a));
                host_read(4'(b), 2'(a), rd);
                chk($sformatf("R9 sweep bank %0d addr %0d", b, a), 32'(rd), 32'(exp));
            end
        chk("R6 sweep flag", 32'(core_out_flag), 32'(m_outflag));

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule